// File: doc/BRIEF.md
# Phase-Increment and Post-Divider Calculator

This block turns a requested output frequency, given in hertz as an unsigned integer, into the two control values a clock synthesizer needs. The synthesizer has a phase accumulator clocked at 200 MHz. A ×16 clock multiplier follows the accumulator, and a divide-by-2^(D+1) stage comes last. The resulting output frequency is N × 200 MHz × 16 / (2^(D+1) × 2^32). The block chooses the power-of-two divider code D first. It chooses D so that the accumulator's top bit toggles at a rate between 6.25 MHz and 12.5 MHz. It then finds the 32-bit increment N with a restoring shift-subtract division that yields one quotient bit per clock.

A caller presents a frequency with a one-cycle `start`. While the block computes it holds `busy` high, and it ignores further starts. `done` pulses for one cycle when the results are ready. A request that is zero or lies above the supported top (100 MHz) raises `range_err` and leaves the last good N and D in place.

Top module: `dds_word_calc`

## Requirements
- R1: While reset is high and after it is released, `n_word` = 0, `d_code` = 0, `range_err` = 0, `done` = 0 and `busy` = 0.
- R2: For a valid request f, `d_code` is the smallest D ≥ 0 with f × 2^(D+1) ≥ 100,000,000.
- R3: For a valid request, `n_word` equals floor(f × 2^(D+29) / 200,000,000) and lies in [2^27, 2^28].
- R4: A request of 12,500,000 Hz gives `n_word` = 0x08000000 and `d_code` = 2.
- R5: A request of 12,412,500 Hz gives `n_word` = 0x0FE353F7 and `d_code` = 3.
- R6: For a valid request accepted at clock edge E, `done` is high for exactly one cycle after edge E+D+66. `busy` is high from after E until that same edge.
- R7: A request of 0 or above 100,000,000 Hz raises `range_err` and pulses `done` after the accepting edge, and leaves `n_word` and `d_code` unchanged.
- R8: A `start` while `busy` is high is ignored. The running calculation completes with the frequency it accepted.
- R9: A completed valid request clears `range_err`.
- R10: The bounds work: 1 Hz gives D = 26 and N = 180,143,985, and 100,000,000 Hz gives D = 0 and N = 0x10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, honoured only when idle |
| freq_hz | input | 32 | Requested output frequency in Hz |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle result strobe |
| range_err | output | 1 | Last request was out of range |
| n_word | output | 32 | Phase-increment word N |
| d_code | output | 5 | Post-divider code D |

## Verification
The result of a valid request is due D+66 edges after the edge that accepts it. D+1 of those edges go to the octave search, 64 to the division and one to registering the outputs. A rejected request answers after a single edge. The bench holds a behavioural timing model with a countdown loaded with that latency. On every falling edge it compares `done` and `busy` against the model, and it compares N, D and the error flag in the cycle that the model marks as due. Requests fired while busy are applied to the model too, so an accidental acceptance shows up as a timing or value mismatch.

// File: rtl/dds_calc_pkg.sv
package dds_calc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCALE,
    ST_DIVIDE
  } calc_state_t;
endpackage

// File: rtl/dds_octave_scaler.sv
// Finds the smallest divider code that lifts f*2^(D+1) to the octave floor.
module dds_octave_scaler #(
  parameter int FW     = 32,
  parameter int AW     = 64,
  parameter int DCW    = 5,
  parameter int THRESH = 100_000_000,
  parameter int MAX_D  = 26
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [FW-1:0]  freq,
  output logic           busy,
  output logic           fin,
  output logic [DCW-1:0] d
);
  logic [AW-1:0] acc;
  logic          reached;

  assign reached = acc >= AW'(THRESH);
  assign fin     = busy && reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      d    <= '0;
      acc  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      d    <= '0;
      acc  <= {{(AW-FW){1'b0}}, freq} << 1;
    end else if (busy) begin
      if (reached) begin
        busy <= 1'b0;
      end else begin
        d   <= d + 1'b1;
        acc <= acc << 1;
      end
    end
  end

  // R2: a nonzero request never needs a code past the 1 Hz case
  assert_octave_bound_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(d) <= MAX_D));

endmodule

// File: rtl/dds_restoring_div.sv
// Restoring divider: one quotient bit per clock, MSB of the dividend first.
module dds_restoring_div #(
  parameter int DW = 64,
  parameter int VW = 28,
  parameter int QW = 32,
  localparam int RW = VW + 1,
  localparam int CW = $clog2(DW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          fin,
  output logic [QW-1:0] quot
);
  logic [DW-1:0] work;
  logic [RW-1:0] rem;
  logic [RW-1:0] shifted;
  logic [RW-1:0] rem_n;
  logic [CW-1:0] cnt;
  logic          ge;

  always_comb begin
    shifted = {rem[RW-2:0], work[DW-1]};
    ge      = shifted >= {1'b0, divisor};
    rem_n   = ge ? (shifted - {1'b0, divisor}) : shifted;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work <= '0;
      rem  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        work <= dividend;
        rem  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        work <= {work[DW-2:0], ge};
        rem  <= rem_n;
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(DW-1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quot = work[QW-1:0];

  // R3: partial remainder stays below the divisor at every step
  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < {1'b0, divisor}));

  // R3: the full quotient fits in the output word
  assert_quot_fits_R3: assert property (@(posedge clk) disable iff (rst)
    fin |-> (work[DW-1:QW] == '0));

endmodule

// File: rtl/dds_word_calc.sv
module dds_word_calc
  import dds_calc_pkg::*;
#(
  parameter int FW        = 32,
  parameter int NW        = 32,
  parameter int DCW       = 5,
  parameter int ACC_HZ    = 200_000_000,
  parameter int OCT_LO_HZ = 6_250_000,
  parameter int MULT      = 16,
  parameter int F_MAX     = 100_000_000,
  parameter int DVW       = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [FW-1:0]  freq_hz,
  output logic           busy,
  output logic           done,
  output logic           range_err,
  output logic [NW-1:0]  n_word,
  output logic [DCW-1:0] d_code
);
  localparam int THRESH     = OCT_LO_HZ * MULT;
  localparam int SHIFT_BASE = NW + 1 - $clog2(MULT);
  localparam int VW         = $clog2(ACC_HZ + 1);
  localparam int MAX_D      = $clog2(THRESH) - 1;
  localparam longint N_LO   = (longint'(OCT_LO_HZ) << NW) / longint'(ACC_HZ);
  localparam longint N_HI   = 2 * N_LO;

  calc_state_t     state;
  logic [FW-1:0]   freq_q;
  logic            ok_req;
  logic            sc_go;
  logic            sc_busy;
  logic            sc_fin;
  logic [DCW-1:0]  sc_d;
  logic [DVW-1:0]  dividend;
  logic            dv_busy;
  logic            dv_fin;
  logic [NW-1:0]   dv_quot;

  assign ok_req   = (freq_hz != '0) && (freq_hz <= FW'(F_MAX));
  assign sc_go    = (state == ST_IDLE) && start && ok_req;
  assign dividend = {{(DVW-FW){1'b0}}, freq_q} << (SHIFT_BASE + int'(sc_d));
  assign busy     = (state != ST_IDLE);

  dds_octave_scaler #(
    .FW(FW), .AW(DVW), .DCW(DCW), .THRESH(THRESH), .MAX_D(MAX_D)
  ) u_scale (
    .clk(clk), .rst(rst), .go(sc_go), .freq(freq_hz),
    .busy(sc_busy), .fin(sc_fin), .d(sc_d)
  );

  dds_restoring_div #(
    .DW(DVW), .VW(VW), .QW(NW)
  ) u_div (
    .clk(clk), .rst(rst), .go(sc_fin), .dividend(dividend),
    .divisor(VW'(ACC_HZ)), .busy(dv_busy), .fin(dv_fin), .quot(dv_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      freq_q    <= '0;
      done      <= 1'b0;
      range_err <= 1'b0;
      n_word    <= '0;
      d_code    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (ok_req) begin
              freq_q <= freq_hz;
              state  <= ST_SCALE;
            end else begin
              range_err <= 1'b1;
              done      <= 1'b1;
            end
          end
        end
        ST_SCALE: begin
          if (sc_fin) state <= ST_DIVIDE;
        end
        ST_DIVIDE: begin
          if (dv_fin) begin
            n_word    <= dv_quot;
            d_code    <= sc_d;
            range_err <= 1'b0;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a good result always lands inside the accumulator octave
  assert_n_octave_R3: assert property (@(posedge clk) disable iff (rst)
    (done && !range_err) |-> (longint'(n_word) >= N_LO && longint'(n_word) <= N_HI));

  // R7: a rejected request leaves the previous words in place
  assert_err_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (done && range_err) |-> ($stable(n_word) && $stable(d_code)));

  // R6: results are only announced once the engine is idle again
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: the scaler and divider never run at the same time
  assert_one_stage_R6: assert property (@(posedge clk) disable iff (rst)
    !(sc_busy && dv_busy));

endmodule

// File: tb/sim_dds_word_calc.sv
module sim_dds_word_calc;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] freq;
  logic        busy, done, range_err;
  logic [31:0] n_word;
  logic [4:0]  d_code;

  always #5 clk = ~clk;

  dds_word_calc u0 (
    .clk(clk), .rst(rst), .start(start), .freq_hz(freq),
    .busy(busy), .done(done), .range_err(range_err),
    .n_word(n_word), .d_code(d_code)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void ref_calc(input logic [31:0] f, output logic [4:0] d,
                                   output logic [31:0] n);
    longint unsigned fl = longint'(f);
    int k = 0;
    while ((fl << (k + 1)) < 64'd100_000_000) k++;
    d = 5'(k);
    n = 32'((fl << (k + 29)) / 64'd200_000_000);
  endfunction

  // behavioural timing model
  int          m_cnt;
  logic        m_done, m_busy, m_err;
  logic [31:0] m_n, p_n;
  logic [4:0]  m_d, p_d;
  bit          live = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_done = 0; m_busy = 0; m_err = 0;
      m_n = 0; m_d = 0; p_n = 0; p_d = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_busy = 0; m_err = 0; m_n = p_n; m_d = p_d;
        end
      end else if (start) begin
        if (freq == 0 || freq > 32'd100_000_000) begin
          m_done = 1; m_err = 1;
        end else begin
          ref_calc(freq, p_d, p_n);
          m_cnt  = int'(p_d) + 66;
          m_busy = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (live) begin
      chk(done === m_done, "R6", "done", longint'(done), longint'(m_done));
      chk(busy === m_busy, "R6", "busy", longint'(busy), longint'(m_busy));
      if (m_done) begin
        chk(range_err === m_err, "R7", "range_err", longint'(range_err), longint'(m_err));
        chk(d_code === m_d, "R2", "d_code", longint'(d_code), longint'(m_d));
        chk(n_word === m_n, "R3", "n_word", longint'(n_word), longint'(m_n));
      end
    end
  end

  task automatic run(input logic [31:0] f);
    @(negedge clk);
    freq = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tests();
    logic [31:0] en;
    logic [4:0]  ed;
    rst = 1'b1; start = 1'b0; freq = '0;
    repeat (3) @(negedge clk);
    chk(n_word == 0 && d_code == 0, "R1", "words in reset", longint'(n_word), 0);
    chk(!range_err && !done && !busy, "R1", "flags in reset",
        longint'({range_err, done, busy}), 0);
    rst = 1'b0;
    live = 1;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after reset", longint'({busy, done}), 0);

    run(32'd12_500_000);
    chk(n_word == 32'h0800_0000, "R4", "n_word", longint'(n_word), 64'h0800_0000);
    chk(d_code == 5'd2, "R4", "d_code", longint'(d_code), 2);

    run(32'd12_412_500);
    chk(n_word == 32'h0FE3_53F7, "R5", "n_word", longint'(n_word), 64'h0FE3_53F7);
    chk(d_code == 5'd3, "R5", "d_code", longint'(d_code), 3);

    run(32'd1);
    chk(n_word == 32'd180_143_985, "R10", "n at 1 Hz", longint'(n_word), 180_143_985);
    chk(d_code == 5'd26, "R10", "d at 1 Hz", longint'(d_code), 26);

    run(32'd100_000_000);
    chk(n_word == 32'h1000_0000, "R10", "n at top", longint'(n_word), 64'h1000_0000);
    chk(d_code == 5'd0, "R10", "d at top", longint'(d_code), 0);

    run(32'd0);
    chk(range_err == 1'b1, "R7", "err on zero", longint'(range_err), 1);
    chk(n_word == 32'h1000_0000 && d_code == 0, "R7", "words kept on zero",
        longint'(n_word), 64'h1000_0000);

    run(32'd100_000_001);
    chk(range_err == 1'b1, "R7", "err above top", longint'(range_err), 1);
    chk(n_word == 32'h1000_0000, "R7", "n kept above top", longint'(n_word), 64'h1000_0000);

    run(32'd3_000_000);
    chk(range_err == 1'b0, "R9", "err cleared", longint'(range_err), 0);
    ref_calc(32'd3_000_000, ed, en);
    chk(n_word == en && d_code == ed, "R3", "n at 3 MHz", longint'(n_word), longint'(en));

    // R8: a second strobe mid-run must not disturb the first request
    @(negedge clk);
    freq = 32'd7_000_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    freq = 32'd55_000_000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    ref_calc(32'd7_000_000, ed, en);
    chk(n_word == en, "R8", "n after busy strobe", longint'(n_word), longint'(en));
    chk(d_code == ed, "R8", "d after busy strobe", longint'(d_code), longint'(ed));
    @(negedge clk);

    foreach (pat[i]) begin
      run(pat[i]);
      ref_calc(pat[i], ed, en);
      chk(d_code == ed, "R2", "d pattern", longint'(d_code), longint'(ed));
      chk(n_word >= 32'h0800_0000 && n_word <= 32'h1000_0000, "R3", "n octave",
          longint'(n_word), longint'(en));
    end
  endtask

  logic [31:0] pat [6] = '{32'd1000, 32'd50_000_000, 32'd6_250_000,
                           32'd99_999_999, 32'd49_999_999, 32'd777};

  initial begin
    fork
      tests();
      begin
        while (cycles < 150_000) @(negedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule